// File: doc/BRIEF.md
# SPI Serial Memory Slave Front End

This block is the slave side of a four-wire serial link in front of a small byte-addressed memory. It works in the chip clock domain. The serial clock, select, data-in and pause pins are brought in through synchronizers, and the block acts on the synchronized edges. A transaction opens when select falls. The first byte is an instruction, and for memory accesses one bit of that instruction is the top address bit. For those accesses a second byte carries the low eight address bits, and data bytes follow until select rises.

Read bytes come from an external register array through a combinational address/data port. The read address steps up after every byte and rolls over from the last location to zero. Write bytes, status-register writes and write-enable or write-disable requests are passed to a neighbouring write controller as single-cycle pulses. That controller owns protection, page handling and busy timing. A pause input freezes a transfer at any bit, and the transfer then resumes from that same bit.

Top module: `spi_mem_slave`

## Requirements
- R1: Clock polarity idle-low (mode 0) and idle-high (mode 3) both work: data in is sampled on rising serial-clock edges and data out changes on falling edges.
- R2: Bytes move most significant bit first. Instruction 0000_A011 (A = address bit 8) followed by a low address byte starts a read, and each later byte returns the array content at the current address.
- R3: During a read the address increments after every byte and wraps from 0x1FF to 0x000 for as long as select stays low.
- R4: Instruction 0000_A010 plus an address byte starts a write. Each completed data byte gives one wr_valid pulse carrying the current address and the byte, and the address then increments.
- R5: A complete 0x06 instruction gives one wren_pulse and a complete 0x04 gives one wrdi_pulse. Each pulse is issued when select rises.
- R6: Instruction 0x05 returns stat_in MSB first, repeated every byte. Instruction 0x01 gives one wrsr_valid pulse with the next byte on wr_data.
- R7: Any other instruction byte is rejected. so_oe stays low and no pulse is produced until select rises.
- R8: While hold_n is low, so_oe is low and serial-clock edges are ignored. When hold_n returns high, the transfer continues from the same bit.
- R9: so_oe is high only during read-data or status-read phases while select is low.
- R10: Serial-clock edges are ignored while select is high. A falling select clears the bit count and starts a new instruction phase.
- R11: If select rises partway through a byte, that byte is dropped and nothing is committed for it.
- R12: After reset so_oe is low and no pulse output is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock pin |
| cs_n | input | 1 | Active-low select pin |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Active-low pause pin |
| so | output | 1 | Serial data out value |
| so_oe | output | 1 | Output enable for so; low means high impedance |
| rd_addr | output | ADDR_W | Read address to the register array |
| rd_data | input | 8 | Array byte at rd_addr |
| stat_in | input | 8 | Status byte from the write controller |
| wr_valid | output | 1 | One-cycle pulse: write byte ready |
| wr_addr | output | ADDR_W | Address for the write byte |
| wr_data | output | 8 | Write byte or status-write byte |
| wrsr_valid | output | 1 | One-cycle pulse: status write byte ready |
| wren_pulse | output | 1 | One-cycle pulse: write enable request |
| wrdi_pulse | output | 1 | One-cycle pulse: write disable request |

## Verification
A pin change reaches the block's registers SYNC_STAGES+1 clock cycles after it is applied: two synchronizer flops, then the state register. An so bit is therefore valid three cycles after a falling serial clock, and a pulse appears three cycles after the final rising edge or after select rises. The bench holds every serial-clock phase for eight chip cycles and samples so just before each rising edge, well after the settling point. It reads pulse counters only after a further two half-periods of idle. Hold and select changes are spaced half a period away from serial-clock edges, so no event lands in the same cycle as a gated edge.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_CMD,
      ST_ADDR,
      ST_RDATA,
      ST_WDATA,
      ST_STAT,
      ST_WSR,
      ST_PEND_EN,
      ST_PEND_DIS,
      ST_IGNORE
   } xfer_state_t;

   localparam logic [7:0] OPC_SET_WE   = 8'h06;
   localparam logic [7:0] OPC_CLR_WE   = 8'h04;
   localparam logic [7:0] OPC_STAT_RD  = 8'h05;
   localparam logic [7:0] OPC_STAT_WR  = 8'h01;

   // memory access opcodes: 0000_A01x, x=1 read, x=0 write
   function automatic xfer_state_t decode_op(input logic [7:0] op);
      xfer_state_t nxt;
      if (op[7:4] == 4'h0 && op[2:1] == 2'b01) nxt = ST_ADDR;
      else if (op == OPC_SET_WE)                nxt = ST_PEND_EN;
      else if (op == OPC_CLR_WE)                nxt = ST_PEND_DIS;
      else if (op == OPC_STAT_RD)               nxt = ST_STAT;
      else if (op == OPC_STAT_WR)               nxt = ST_WSR;
      else                                      nxt = ST_IGNORE;
      return nxt;
   endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
   parameter int          W      = 4,
   parameter int          STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("spi_pin_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
      end else begin
         stg[0] <= din;
         for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
      end
   end

   assign dout = stg[STAGES-1];

endmodule

// File: rtl/spi_edge_det.sv
module spi_edge_det #(
   parameter int          W       = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl,
   output logic [W-1:0] rise,
   output logic [W-1:0] fall
);

   logic [W-1:0] prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= RST_VAL;
      else        prev <= lvl;
   end

   assign rise = lvl & ~prev;
   assign fall = ~lvl & prev;

endmodule

// File: rtl/spi_mem_core.sv
module spi_mem_core
   import spi_mem_pkg::*;
#(
   parameter int ADDR_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sck_rise,
   input  logic              sck_fall,
   input  logic              cs_fall,
   input  logic              cs_rise,
   input  logic              cs_low,
   input  logic              hold_ok,
   input  logic              si_s,
   input  logic [7:0]        rd_data,
   input  logic [7:0]        stat_in,
   output logic              so,
   output logic              so_oe,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              wr_valid,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [7:0]        wr_data,
   output logic              wrsr_valid,
   output logic              wren_pulse,
   output logic              wrdi_pulse
);

   localparam int BYTE_W = 8;
   localparam logic [2:0] LAST_BIT = 3'(BYTE_W - 1);

   xfer_state_t       state;
   logic [2:0]        bit_cnt;
   logic [6:0]        shreg;
   logic [ADDR_W-1:0] addr;
   logic              addr_hi;
   logic              rd_mode;
   logic              so_q;
   logic [7:0]        rx_byte;
   logic [ADDR_W-1:0] load_addr;
   logic [7:0]        cur_byte;
   logic              rise_ok;
   logic              fall_ok;
   logic              byte_done;

   generate
      if (ADDR_W < 1 || ADDR_W > 9) begin : g_bad_aw
         $error("spi_mem_core: ADDR_W must be 1..9");
      end
      if (ADDR_W == 9) begin : g_hi_bit
         assign load_addr = {addr_hi, rx_byte};
      end else begin : g_no_hi_bit
         assign load_addr = rx_byte[ADDR_W-1:0];
      end
   endgenerate

   assign rise_ok   = sck_rise & cs_low & hold_ok;
   assign fall_ok   = sck_fall & cs_low & hold_ok;
   assign rx_byte   = {shreg, si_s};
   assign byte_done = rise_ok && (bit_cnt == LAST_BIT);
   assign cur_byte  = (state == ST_RDATA) ? rd_data : stat_in;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         bit_cnt    <= '0;
         shreg      <= '0;
         addr       <= '0;
         addr_hi    <= 1'b0;
         rd_mode    <= 1'b0;
         so_q       <= 1'b0;
         wr_valid   <= 1'b0;
         wr_addr    <= '0;
         wr_data    <= '0;
         wrsr_valid <= 1'b0;
         wren_pulse <= 1'b0;
         wrdi_pulse <= 1'b0;
      end else begin
         wr_valid   <= 1'b0;
         wrsr_valid <= 1'b0;
         wren_pulse <= 1'b0;
         wrdi_pulse <= 1'b0;
         if (cs_fall) begin
            state   <= ST_CMD;
            bit_cnt <= '0;
         end else if (cs_rise) begin
            if (bit_cnt == '0) begin
               if (state == ST_PEND_EN)  wren_pulse <= 1'b1;
               if (state == ST_PEND_DIS) wrdi_pulse <= 1'b1;
            end
            state   <= ST_IDLE;
            bit_cnt <= '0;
         end else if (rise_ok) begin
            shreg   <= rx_byte[6:0];
            bit_cnt <= bit_cnt + 3'd1;
            if (byte_done) begin
               case (state)
                  ST_CMD: begin
                     state   <= decode_op(rx_byte);
                     addr_hi <= rx_byte[3];
                     rd_mode <= rx_byte[0];
                  end
                  ST_ADDR: begin
                     addr  <= load_addr;
                     state <= rd_mode ? ST_RDATA : ST_WDATA;
                  end
                  ST_RDATA: addr <= addr + ADDR_W'(1);
                  ST_WDATA: begin
                     wr_valid <= 1'b1;
                     wr_addr  <= addr;
                     wr_data  <= rx_byte;
                     addr     <= addr + ADDR_W'(1);
                  end
                  ST_WSR: begin
                     wrsr_valid <= 1'b1;
                     wr_data    <= rx_byte;
                     state      <= ST_IGNORE;
                  end
                  default: ;
               endcase
            end
         end else if (fall_ok && (state == ST_RDATA || state == ST_STAT)) begin
            so_q <= cur_byte[LAST_BIT - bit_cnt];
         end
      end
   end

   assign so      = so_q;
   assign so_oe   = (state == ST_RDATA || state == ST_STAT) && cs_low && hold_ok;
   assign rd_addr = addr;

   // R10
   cs_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_fall |=> (bit_cnt == '0 && state == ST_CMD));

   // R10
   cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_low && !cs_rise && !cs_fall) |=> $stable(bit_cnt));

   // R8
   hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold_ok && !cs_fall && !cs_rise) |=>
         ($stable(bit_cnt) && $stable(addr) && $stable(so_q) && $stable(shreg)));

   // R3
   rd_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RDATA && byte_done && !cs_fall && !cs_rise && addr == '1) |=> (addr == '0));

   // R4
   wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |=> !wr_valid);

   // R7
   ignore_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IGNORE && !cs_rise && !cs_fall) |=> (state == ST_IGNORE && !so_oe));

   // R5
   pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wr_valid, wrsr_valid, wren_pulse, wrdi_pulse}));

endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave #(
   parameter int ADDR_W      = 9,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sck,
   input  logic              cs_n,
   input  logic              si,
   input  logic              hold_n,
   output logic              so,
   output logic              so_oe,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic [7:0]        rd_data,
   input  logic [7:0]        stat_in,
   output logic              wr_valid,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [7:0]        wr_data,
   output logic              wrsr_valid,
   output logic              wren_pulse,
   output logic              wrdi_pulse
);

   localparam int PIN_W = 4;
   localparam logic [PIN_W-1:0] PIN_IDLE = 4'b0110; // sck, cs_n, hold_n, si

   logic [PIN_W-1:0] pins_s;
   logic [1:0]       ev_rise;
   logic [1:0]       ev_fall;

   spi_pin_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) i_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  ({sck, cs_n, hold_n, si}),
      .dout (pins_s)
   );

   spi_edge_det #(.W(2), .RST_VAL(2'b01)) i_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .lvl  (pins_s[3:2]),
      .rise (ev_rise),
      .fall (ev_fall)
   );

   spi_mem_core #(.ADDR_W(ADDR_W)) i_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .sck_rise  (ev_rise[1]),
      .sck_fall  (ev_fall[1]),
      .cs_fall   (ev_fall[0]),
      .cs_rise   (ev_rise[0]),
      .cs_low    (~pins_s[2]),
      .hold_ok   (pins_s[1]),
      .si_s      (pins_s[0]),
      .rd_data   (rd_data),
      .stat_in   (stat_in),
      .so        (so),
      .so_oe     (so_oe),
      .rd_addr   (rd_addr),
      .wr_valid  (wr_valid),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .wrsr_valid(wrsr_valid),
      .wren_pulse(wren_pulse),
      .wrdi_pulse(wrdi_pulse)
   );

endmodule

// File: tb/test_spi_mem_slave.sv
module test_spi_mem_slave;
   localparam int AW   = 9;
   localparam int HALF = 8;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic          rst_n, sck, cs_n, si, hold_n;
   logic          so, so_oe;
   logic [AW-1:0] rd_addr, wr_addr;
   logic [7:0]    rd_data, stat_in, wr_data;
   logic          wr_valid, wrsr_valid, wren_pulse, wrdi_pulse;

   function automatic logic [7:0] mem_val(input logic [AW-1:0] a);
      return 8'(32'(a) * 37 + 5);
   endfunction

   assign rd_data = mem_val(rd_addr);

   spi_mem_slave #(.ADDR_W(AW), .SYNC_STAGES(2)) i_spi_mem_slave (
      .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si), .hold_n(hold_n),
      .so(so), .so_oe(so_oe), .rd_addr(rd_addr), .rd_data(rd_data), .stat_in(stat_in),
      .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wrsr_valid(wrsr_valid),
      .wren_pulse(wren_pulse), .wrdi_pulse(wrdi_pulse));

   int n_chk = 0, n_fail = 0;
   int n_wr = 0, n_wrsr = 0, n_wren = 0, n_wrdi = 0;
   logic [AW-1:0] wa [32];
   logic [7:0]    wd [32];
   logic [7:0]    last_sr;
   logic          mode3;
   bit            done = 1'b0;

   always @(posedge clk) begin
      if (wr_valid) begin
         wa[n_wr % 32] = wr_addr;
         wd[n_wr % 32] = wr_data;
         n_wr++;
      end
      if (wrsr_valid) begin last_sr = wr_data; n_wrsr++; end
      if (wren_pulse) n_wren++;
      if (wrdi_pulse) n_wrdi++;
   end

   task automatic check(input bit ok, input string req, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   task automatic waitc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic cs_begin(input bit m3);
      mode3 = m3;
      sck = m3;
      waitc(HALF);
      cs_n = 1'b0;
      waitc(HALF);
   endtask

   task automatic cs_end();
      waitc(HALF);
      cs_n = 1'b1;
      waitc(2 * HALF);
   endtask

   task automatic do_hold(input logic bitv);
      waitc(HALF);
      hold_n = 1'b0;
      waitc(HALF);
      check(so_oe == 1'b0, "R8 hold output off", so_oe, 0);
      si = ~bitv;
      for (int t = 0; t < 3; t++) begin
         sck = 1'b1; waitc(HALF);
         sck = 1'b0; waitc(HALF);
      end
      si = bitv;
      hold_n = 1'b1;
   endtask

   task automatic xfer(input logic [7:0] tx, input int nbits, input int hold_at,
                       output logic [7:0] rx);
      rx = '0;
      for (int i = 0; i < nbits; i++) begin
         if (mode3) sck = 1'b0;
         si = tx[7-i];
         if (i == hold_at) do_hold(tx[7-i]);
         waitc(HALF);
         rx = {rx[6:0], so};
         sck = 1'b1;
         waitc(HALF);
         if (!mode3) sck = 1'b0;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [7:0] rx;
      int base;
      rst_n = 1'b0; sck = 1'b0; cs_n = 1'b1; si = 1'b0; hold_n = 1'b1; stat_in = 8'hA5;
      mode3 = 1'b0;
      waitc(5);
      rst_n = 1'b1;
      waitc(5);

      // R12 reset state
      check(so_oe == 1'b0, "R12 so_oe after reset", so_oe, 0);
      check((n_wr + n_wrsr + n_wren + n_wrdi) == 0, "R12 no pulses", n_wr + n_wrsr + n_wren + n_wrdi, 0);

      // R2 R3 R1: mode 0 read from 0x1FD across the wrap
      cs_begin(1'b0);
      xfer(8'h0B, 8, -1, rx);
      xfer(8'hFD, 8, -1, rx);
      for (int k = 0; k < 5; k++) begin
         xfer(8'h00, 8, -1, rx);
         check(rx == mem_val(AW'(9'h1FD + k)), "R3 read wrap mode0", rx, mem_val(AW'(9'h1FD + k)));
         if (k == 0) check(so_oe == 1'b1, "R9 so_oe in read", so_oe, 1);
      end
      cs_end();
      check(so_oe == 1'b0, "R9 so_oe after select high", so_oe, 0);

      // R1 R2: mode 3 read from 0x023
      cs_begin(1'b1);
      xfer(8'h03, 8, -1, rx);
      xfer(8'h23, 8, -1, rx);
      for (int k = 0; k < 3; k++) begin
         xfer(8'h00, 8, -1, rx);
         check(rx == mem_val(AW'(9'h023 + k)), "R1 read mode3", rx, mem_val(AW'(9'h023 + k)));
      end
      cs_end();

      // R4 R11: write at 0x110, three full bytes then a partial one
      base = n_wr;
      cs_begin(1'b0);
      xfer(8'h0A, 8, -1, rx);
      xfer(8'h10, 8, -1, rx);
      xfer(8'h11, 8, -1, rx);
      xfer(8'h22, 8, -1, rx);
      xfer(8'h33, 8, -1, rx);
      check(so_oe == 1'b0, "R9 so_oe in write", so_oe, 0);
      xfer(8'hF0, 4, -1, rx);
      cs_end();
      check(n_wr == base + 3, "R11 partial write byte dropped", n_wr - base, 3);
      for (int k = 0; k < 3; k++) begin
         check(wa[(base + k) % 32] == AW'(9'h110 + k), "R4 write address",
               wa[(base + k) % 32], 9'h110 + k);
         check(wd[(base + k) % 32] == 8'(8'h11 * (k + 1)), "R4 write data",
               wd[(base + k) % 32], 8'h11 * (k + 1));
      end

      // R5 write enable / disable
      cs_begin(1'b1);
      xfer(8'h06, 8, -1, rx);
      cs_end();
      check(n_wren == 1, "R5 enable pulse", n_wren, 1);
      cs_begin(1'b0);
      xfer(8'h04, 8, -1, rx);
      cs_end();
      check(n_wrdi == 1, "R5 disable pulse", n_wrdi, 1);

      // R11 aborted enable instructions
      cs_begin(1'b0);
      xfer(8'h06, 8, -1, rx);
      xfer(8'h00, 3, -1, rx);
      cs_end();
      cs_begin(1'b0);
      xfer(8'h06, 5, -1, rx);
      cs_end();
      check(n_wren == 1, "R11 partial enable not committed", n_wren, 1);

      // R6 status read and status write
      cs_begin(1'b0);
      xfer(8'h05, 8, -1, rx);
      xfer(8'h00, 8, -1, rx);
      check(rx == 8'hA5, "R6 status read byte 1", rx, 8'hA5);
      xfer(8'h00, 8, -1, rx);
      check(rx == 8'hA5, "R6 status read byte 2", rx, 8'hA5);
      cs_end();
      base = n_wr;
      cs_begin(1'b1);
      xfer(8'h01, 8, -1, rx);
      xfer(8'h5A, 8, -1, rx);
      xfer(8'h77, 8, -1, rx);
      cs_end();
      check(n_wrsr == 1, "R6 status write pulse", n_wrsr, 1);
      check(last_sr == 8'h5A, "R6 status write data", last_sr, 8'h5A);
      check(n_wr == base, "R6 no data write", n_wr - base, 0);

      // R7 rejected instruction
      base = n_wr;
      cs_begin(1'b0);
      xfer(8'hFF, 8, -1, rx);
      xfer(8'h0B, 8, -1, rx);
      check(so_oe == 1'b0, "R7 output off after bad opcode", so_oe, 0);
      xfer(8'h00, 8, -1, rx);
      check(so_oe == 1'b0, "R7 output stays off", so_oe, 0);
      cs_end();
      check(n_wr == base && n_wren == 1 && n_wrdi == 1 && n_wrsr == 1, "R7 no pulses",
            n_wr - base, 0);

      // R8 hold inside a data byte (mode 0)
      cs_begin(1'b0);
      xfer(8'h03, 8, -1, rx);
      xfer(8'h40, 8, -1, rx);
      xfer(8'h00, 8, 3, rx);
      check(rx == mem_val(AW'(9'h040)), "R8 byte across hold", rx, mem_val(AW'(9'h040)));
      xfer(8'h00, 8, -1, rx);
      check(rx == mem_val(AW'(9'h041)), "R8 byte after hold", rx, mem_val(AW'(9'h041)));
      cs_end();

      // R8 hold inside the address byte (mode 3)
      cs_begin(1'b1);
      xfer(8'h03, 8, -1, rx);
      xfer(8'hC3, 8, 5, rx);
      xfer(8'h00, 8, -1, rx);
      check(rx == mem_val(AW'(9'h0C3)), "R8 address across hold", rx, mem_val(AW'(9'h0C3)));
      cs_end();

      // R10 clocks with select high are ignored; select fall restarts
      base = n_wr;
      sck = 1'b0; si = 1'b1;
      for (int t = 0; t < 12; t++) begin
         sck = ~sck;
         waitc(HALF);
      end
      check(so_oe == 1'b0, "R10 idle clocks no output", so_oe, 0);
      check(n_wr == base && n_wren == 1, "R10 idle clocks no pulses", n_wr - base, 0);
      cs_begin(1'b0);
      xfer(8'h0A, 3, -1, rx);
      cs_end();
      cs_begin(1'b0);
      xfer(8'h0B, 8, -1, rx);
      xfer(8'h55, 8, -1, rx);
      xfer(8'h00, 8, -1, rx);
      check(rx == mem_val(AW'(9'h155)), "R10 fresh instruction after abort", rx, mem_val(AW'(9'h155)));
      cs_end();
      check(n_wr == base, "R10 aborted write no pulse", n_wr - base, 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule